// File: doc/BRIEF.md
# Three-Mode Four-Point Transform Butterfly

This block computes one four-point transform per valid input sample through a single shared sum/difference network. Two select inputs choose among three transforms. The plain Hadamard transform is used when neither select is high. An integer core transform doubles two of the odd terms. A halving Hadamard transform shifts every result right by one place. The result is captured in one register stage, so each accepted sample appears one clock later with its own valid flag.

The first layer pairs the outer inputs (`in_s0`, `in_s3`) and the inner inputs (`in_s1`, `in_s2`). Call the results a = s0+s3, d = s0−s3, b = s1+s2 and c = s1−s2. The second layer combines these four values. Operand multiplexers in front of the second-layer adders and a shift stage behind them select the mode, so no adder is duplicated.

The block serves as the row or column kernel of a larger 2D transform engine. Sequencing over a block of samples is left to the surrounding logic. Both selects high is an illegal request. The block then computes the integer transform and flags the result.

Top module: `xform4_butterfly`

## Requirements
- R1: With `sel_int`=0 and `sel_half`=0, a valid sample yields out_y0=a+b, out_y1=d+c, out_y2=a−b, out_y3=d−c.
- R2: With `sel_int`=1 and `sel_half`=0, a valid sample yields out_y0=a+b, out_y1=2d+c, out_y2=a−b, out_y3=d−2c.
- R3: With `sel_int`=0 and `sel_half`=1, each of the four plain-mode results is shifted arithmetically right by one, which rounds toward minus infinity.
- R4: With both selects high, a valid sample yields the integer-mode results of R2, and `out_err` is 1 in the cycle the result appears. For a valid sample with any other select setting, `out_err` is 0. When `in_valid` is low, `out_err` is 0 in the following cycle.
- R5: `out_valid` equals `in_valid` of the previous clock edge. The four outputs change at that same edge.
- R6: While `in_valid` is low, changes to the data and select inputs have no effect, and the four outputs keep their last values.
- R7: A clock edge with `rst_n` low clears all four outputs, `out_valid` and `out_err` to 0.
- R8: The outputs are IN_W+3 bits wide (19 bits by default), so every mode gives the exact result for full-scale inputs from −32768 to 32767 without wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input sample present |
| sel_int | input | 1 | Integer core transform select |
| sel_half | input | 1 | Halving Hadamard select |
| in_s0 | input | 16 | Input sample 0, signed |
| in_s1 | input | 16 | Input sample 1, signed |
| in_s2 | input | 16 | Input sample 2, signed |
| in_s3 | input | 16 | Input sample 3, signed |
| out_valid | output | 1 | Result present |
| out_err | output | 1 | Result came from the illegal select pair |
| out_y0 | output | 19 | Result 0 (a+b), signed |
| out_y1 | output | 19 | Result 1 (odd sum), signed |
| out_y2 | output | 19 | Result 2 (a−b), signed |
| out_y3 | output | 19 | Result 3 (odd difference), signed |

## Verification
The assertions check the control behaviour on every cycle. These are the one-cycle valid latency, the error flag tracking the illegal select pair, outputs held while no sample is offered, and an all-zero sample giving zero results. The arithmetic of each mode is shown only by the bench scenarios. These cover seeded random samples in every select setting and directed full-scale corners that exercise growth and rounding of negative odd values under halving. A reset in the middle of the run shows that the registers clear.

// File: rtl/xfb_pkg.sv
// Shared types for the transform butterfly.
// Assumes the two select inputs are decoded at the block's edge only.
package xfb_pkg;
    typedef enum logic [1:0] {
        MODE_PLAIN = 2'd0,
        MODE_INT   = 2'd1,
        MODE_HALF  = 2'd2
    } xfb_mode_t;

    // Map the select pair to a mode; the illegal pair falls back to integer mode.
    function automatic xfb_mode_t xfb_decode(input logic s_int, input logic s_half);
        if (s_int)       return MODE_INT;
        else if (s_half) return MODE_HALF;
        else             return MODE_PLAIN;
    endfunction
endpackage

// File: rtl/xfb_pair_stage.sv
// First butterfly layer: sums and differences of the outer and inner sample pairs.
// Assumes signed inputs of IN_W bits; results carry one growth bit.
module xfb_pair_stage #(
    parameter int IN_W = 16,
    localparam int SUM_W = IN_W + 1
) (
    input  logic signed [IN_W-1:0]  s0,
    input  logic signed [IN_W-1:0]  s1,
    input  logic signed [IN_W-1:0]  s2,
    input  logic signed [IN_W-1:0]  s3,
    output logic signed [SUM_W-1:0] a,
    output logic signed [SUM_W-1:0] b,
    output logic signed [SUM_W-1:0] c,
    output logic signed [SUM_W-1:0] d
);
    // Sign-extend and form the four pair terms.
    always_comb begin
        a = SUM_W'(s0) + SUM_W'(s3);
        d = SUM_W'(s0) - SUM_W'(s3);
        b = SUM_W'(s1) + SUM_W'(s2);
        c = SUM_W'(s1) - SUM_W'(s2);
    end
endmodule

// File: rtl/xfb_combine.sv
// Second butterfly layer with mode multiplexers and an optional halving shift.
// Assumes pair terms of SUM_W bits; results are SUM_W+2 bits, enough for 2d+c.
module xfb_combine
    import xfb_pkg::*;
#(
    parameter int SUM_W = 17,
    localparam int RES_W = SUM_W + 2,
    localparam int LANES = 4
) (
    input  xfb_mode_t               mode,
    input  logic signed [SUM_W-1:0] a,
    input  logic signed [SUM_W-1:0] b,
    input  logic signed [SUM_W-1:0] c,
    input  logic signed [SUM_W-1:0] d,
    output logic signed [RES_W-1:0] y [LANES]
);
    logic signed [RES_W-1:0] ea, eb, ec, ed;
    logic signed [RES_W-1:0] op_d, op_c;
    logic signed [RES_W-1:0] raw [LANES];
    logic                    dbl;

    // Widen the terms and pick the doubled operands for the odd lanes.
    always_comb begin
        dbl  = (mode == MODE_INT);
        ea   = RES_W'(a);
        eb   = RES_W'(b);
        ec   = RES_W'(c);
        ed   = RES_W'(d);
        op_d = dbl ? (ed <<< 1) : ed;
        op_c = dbl ? (ec <<< 1) : ec;
    end

    // Shared adders: one sum and one difference per pair of lanes.
    always_comb begin
        raw[0] = ea + eb;
        raw[2] = ea - eb;
        raw[1] = op_d + ec;
        raw[3] = ed - op_c;
    end

    // Per-lane halving shift, applied only in halving mode.
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        always_comb y[i] = (mode == MODE_HALF) ? (raw[i] >>> 1) : raw[i];
    end
endmodule

// File: rtl/xform4_butterfly.sv
// Top: shared four-point transform butterfly with one register stage.
// Assumes in_valid qualifies data and selects; outputs hold between samples.
module xform4_butterfly
    import xfb_pkg::*;
#(
    parameter int IN_W = 16,
    localparam int SUM_W = IN_W + 1,
    localparam int OUT_W = IN_W + 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic                    sel_int,
    input  logic                    sel_half,
    input  logic signed [IN_W-1:0]  in_s0,
    input  logic signed [IN_W-1:0]  in_s1,
    input  logic signed [IN_W-1:0]  in_s2,
    input  logic signed [IN_W-1:0]  in_s3,
    output logic                    out_valid,
    output logic                    out_err,
    output logic signed [OUT_W-1:0] out_y0,
    output logic signed [OUT_W-1:0] out_y1,
    output logic signed [OUT_W-1:0] out_y2,
    output logic signed [OUT_W-1:0] out_y3
);
    logic signed [SUM_W-1:0] pa, pb, pc, pd;
    logic signed [OUT_W-1:0] res [4];
    xfb_mode_t               mode;
    logic                    conflict;

    // Decode the select pair and flag the illegal combination.
    always_comb begin
        mode     = xfb_decode(sel_int, sel_half);
        conflict = sel_int & sel_half;
    end

    xfb_pair_stage #(.IN_W(IN_W)) u_pair (
        .s0(in_s0), .s1(in_s1), .s2(in_s2), .s3(in_s3),
        .a(pa), .b(pb), .c(pc), .d(pd)
    );

    xfb_combine #(.SUM_W(SUM_W)) u_comb (
        .mode(mode), .a(pa), .b(pb), .c(pc), .d(pd), .y(res)
    );

    // Output register: load on a valid sample, hold otherwise, clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_err   <= 1'b0;
            out_y0    <= '0;
            out_y1    <= '0;
            out_y2    <= '0;
            out_y3    <= '0;
        end else begin
            out_valid <= in_valid;
            out_err   <= in_valid & conflict;
            if (in_valid) begin
                out_y0 <= res[0];
                out_y1 <= res[1];
                out_y2 <= res[2];
                out_y3 <= res[3];
            end
        end
    end
endmodule

// File: rtl/xfb_checker.sv
// Protocol checker for xform4_butterfly, attached by bind.
// Assumes the top's default port widths are passed through parameters.
module xfb_checker #(
    parameter int IN_W  = 16,
    parameter int OUT_W = 19
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    in_valid,
    input logic                    sel_int,
    input logic                    sel_half,
    input logic signed [IN_W-1:0]  in_s0,
    input logic signed [IN_W-1:0]  in_s1,
    input logic signed [IN_W-1:0]  in_s2,
    input logic signed [IN_W-1:0]  in_s3,
    input logic                    out_valid,
    input logic                    out_err,
    input logic signed [OUT_W-1:0] out_y0,
    input logic signed [OUT_W-1:0] out_y1,
    input logic signed [OUT_W-1:0] out_y2,
    input logic signed [OUT_W-1:0] out_y3
);
    assert_valid_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    assert_valid_drops_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    assert_err_on_conflict_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && sel_int && sel_half) |=> out_err);

    assert_err_absent_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && sel_int && sel_half) |=> !out_err);

    assert_hold_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_y0) && $stable(out_y1) && $stable(out_y2) && $stable(out_y3)));

    assert_zero_sample_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_s0 == 0 && in_s1 == 0 && in_s2 == 0 && in_s3 == 0)
        |=> (out_y0 == 0 && out_y1 == 0 && out_y2 == 0 && out_y3 == 0));
endmodule

bind xform4_butterfly xfb_checker #(.IN_W(IN_W), .OUT_W(OUT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .sel_int(sel_int),
    .sel_half(sel_half), .in_s0(in_s0), .in_s1(in_s1), .in_s2(in_s2),
    .in_s3(in_s3), .out_valid(out_valid), .out_err(out_err),
    .out_y0(out_y0), .out_y1(out_y1), .out_y2(out_y2), .out_y3(out_y3)
);

// File: tb/test_xform4_butterfly.sv
module test_xform4_butterfly;
    localparam int CLK_PERIOD = 10;
    localparam int IN_W  = 16;
    localparam int OUT_W = 19;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0, sel_int = 1'b0, sel_half = 1'b0;
    logic signed [IN_W-1:0] in_s0 = '0, in_s1 = '0, in_s2 = '0, in_s3 = '0;
    logic out_valid, out_err;
    logic signed [OUT_W-1:0] out_y0, out_y1, out_y2, out_y3;

    int total = 0;
    int bad = 0;
    int ey [4];
    int seed_dummy;

    always #(CLK_PERIOD/2) clk = ~clk;

    xform4_butterfly i_xform4_butterfly (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .sel_int(sel_int),
        .sel_half(sel_half), .in_s0(in_s0), .in_s1(in_s1), .in_s2(in_s2),
        .in_s3(in_s3), .out_valid(out_valid), .out_err(out_err),
        .out_y0(out_y0), .out_y1(out_y1), .out_y2(out_y2), .out_y3(out_y3)
    );

    // Expected result of one lane from the requirement formulas.
    function automatic int expect_lane(int lane, int s0, int s1, int s2, int s3,
                                       logic si, logic sh);
        int a, b, c, d, r;
        a = s0 + s3; d = s0 - s3; b = s1 + s2; c = s1 - s2;
        case (lane)
            0: r = a + b;
            2: r = a - b;
            1: r = si ? 2*d + c : d + c;
            default: r = si ? d - 2*c : d - c;
        endcase
        if (sh && !si) r = r >>> 1;
        return r;
    endfunction

    task automatic check(string tag, string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic check_outputs(string tag);
        check(tag, "y0", int'(out_y0), ey[0]);
        check(tag, "y1", int'(out_y1), ey[1]);
        check(tag, "y2", int'(out_y2), ey[2]);
        check(tag, "y3", int'(out_y3), ey[3]);
    endtask

    // Offer one sample at a falling edge and check it after the next rising edge.
    task automatic apply(string tag, int s0, int s1, int s2, int s3, logic si, logic sh);
        @(negedge clk);
        in_valid = 1'b1; sel_int = si; sel_half = sh;
        in_s0 = IN_W'(s0); in_s1 = IN_W'(s1); in_s2 = IN_W'(s2); in_s3 = IN_W'(s3);
        for (int k = 0; k < 4; k++) ey[k] = expect_lane(k, s0, s1, s2, s3, si, sh);
        @(posedge clk); #1;
        check(tag, "out_valid", int'(out_valid), 1);
        check(tag, "out_err", int'(out_err), int'(si & sh));
        check_outputs(tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        seed_dummy = $urandom(32'h1A2B);
        repeat (3) @(posedge clk);
        #1;
        ey = '{0, 0, 0, 0};
        check("R7", "out_valid", int'(out_valid), 0);
        check("R7", "out_err", int'(out_err), 0);
        check_outputs("R7");
        @(negedge clk); rst_n = 1'b1;

        // Directed corners per mode
        apply("R1", 1, 2, 3, 4, 1'b0, 1'b0);
        apply("R2", 1, 2, 3, 4, 1'b1, 1'b0);
        apply("R3", 1, 2, 3, 4, 1'b0, 1'b1);
        apply("R3", -3, 0, 0, 0, 1'b0, 1'b1);
        apply("R3", 0, 0, 1, 0, 1'b0, 1'b1);
        apply("R4", 5, -7, 9, -11, 1'b1, 1'b1);
        apply("R8", 32767, 32767, -32768, -32768, 1'b1, 1'b0);
        apply("R8", -32768, -32768, 32767, 32767, 1'b1, 1'b0);
        apply("R8", 32767, -32768, 32767, -32768, 1'b1, 1'b0);
        apply("R8", 32767, 32767, 32767, 32767, 1'b0, 1'b0);
        apply("R8", -32768, -32768, -32768, -32768, 1'b0, 1'b1);

        // R6: idle cycle with changed data keeps outputs, drops valid and err
        apply("R4", 100, 200, -300, 400, 1'b1, 1'b1);
        @(negedge clk);
        in_valid = 1'b0; sel_int = 1'b0; sel_half = 1'b1;
        in_s0 = 16'sd999; in_s1 = -16'sd5; in_s2 = 16'sd77; in_s3 = 16'sd1;
        @(posedge clk); #1;
        check("R5", "out_valid", int'(out_valid), 0);
        check("R4", "out_err idle", int'(out_err), 0);
        check_outputs("R6");
        @(posedge clk); #1;
        check_outputs("R6");

        // Seeded random samples across all select settings
        for (int n = 0; n < 400; n++) begin
            int r0, r1, r2, r3;
            logic si, sh;
            r0 = $signed(16'($urandom)); r1 = $signed(16'($urandom));
            r2 = $signed(16'($urandom)); r3 = $signed(16'($urandom));
            si = 1'($urandom); sh = 1'($urandom);
            if (si && sh)       apply("R4", r0, r1, r2, r3, si, sh);
            else if (si)        apply("R2", r0, r1, r2, r3, si, sh);
            else if (sh)        apply("R3", r0, r1, r2, r3, si, sh);
            else                apply("R1", r0, r1, r2, r3, si, sh);
        end

        // R7: reset in mid run clears everything
        @(negedge clk);
        rst_n = 1'b0; in_valid = 1'b1;
        @(posedge clk); #1;
        ey = '{0, 0, 0, 0};
        check("R7", "out_valid", int'(out_valid), 0);
        check("R7", "out_err", int'(out_err), 0);
        check_outputs("R7");
        @(negedge clk); rst_n = 1'b1; in_valid = 1'b0;
        apply("R5", -1, -1, 1, 1, 1'b0, 1'b0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule